// File: doc/BRIEF.md
# Single-Wire Bus Master Engine

This block is a bit-level master for a single-wire open-drain bus. It takes one command at a time and turns it into a slot with fixed timing: a bus reset with presence detection, a read slot, a write-0 slot or a write-1 slot. All slot durations are derived from the system clock through a cycles-per-microsecond parameter. It pulls the line low only by asserting an output enable while the driven level stays 0. The line is released by dropping the enable, and the external resistor then pulls it high.

Two hold modes sit outside the timed slots and exist to support parasite-powered devices. The strong pull-up mode drives the line high so those devices get enough current. The forced pull-down mode keeps the line low for as long as needed to recover a hung device. Each hold mode lasts until a release command arrives. A timed slot finishes with a one-cycle done strobe and a result bit: the sampled line level for a read, or the presence flag for a bus reset. The line input passes through a two-flop synchronizer before it is sampled.

Top module: `swire_master`

## Requirements
- R1: After a synchronous reset, line_oe, line_drv, busy and done are all 0.
- R2: Command code 0 (bus reset) holds line_oe high for 500 us. It then releases the line, and busy stays high for 981 us in total before done.
- R3: For command code 0, result is 1 when the synchronized line is low at the point 60 us after release, and 0 when it is high.
- R4: Command code 1 (read) holds line_oe high for 5 us. It samples the synchronized line 6 us after release and busy lasts 61 us. Result is 1 for a high line and 0 for a low line.
- R5: Command code 2 (write 0) holds line_oe high for 60 us, with busy lasting 61 us.
- R6: Command code 3 (write 1) holds line_oe high for 10 us, with busy lasting 61 us.
- R7: line_drv is 1 only while the strong pull-up is active. During all timed slots and in idle it is 0.
- R8: Command code 4, accepted in idle, sets line_oe=1 and line_drv=1 and keeps them there. Command code 6 then returns both to 0.
- R9: Command code 5, accepted in idle, sets line_oe=1 and line_drv=0 and keeps them there until command code 6 arrives.
- R10: A command given while busy is high changes neither the running slot's timing nor anything after it. While a hold mode is active, every code other than 6 is ignored.
- R11: done is high for exactly one cycle, and busy falls in that same cycle. result is valid while done is high. Hold commands give no done.
- R12: Codes 6 and 7 given in idle have no effect. busy and line_oe stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, sampled on the rising edge |
| cmd_code | input | 3 | Command code (0 reset, 1 read, 2 write 0, 3 write 1, 4 pull-up, 5 pull-down, 6 release) |
| busy | output | 1 | High while a timed slot runs |
| done | output | 1 | One-cycle strobe at slot end |
| result | output | 1 | Read bit or presence flag, valid with done |
| line_in | input | 1 | Asynchronous level of the bus line |
| line_oe | output | 1 | Driver enable for the bus pin |
| line_drv | output | 1 | Level driven when line_oe is high |

## Verification
A sequencer stuck in the wrong phase or a timer loaded with the wrong length shows up at the ports within one slot. The line_oe high time and the busy length then differ from the expected microsecond counts by whole cycles, so the bench counts both exactly, cycle by cycle. A sample taken at the wrong moment shows as a wrong result when the device pulls the line low only in a window that begins before or after the 6 us point. A hold mode entered or left incorrectly shows as line_oe or line_drv changing on a command that should have been ignored. It becomes visible on the next clock edge.

// File: rtl/swire_pkg.sv
package swire_pkg;

  typedef enum logic [2:0] {
    CMD_BUS_RESET = 3'd0,
    CMD_READ      = 3'd1,
    CMD_WRITE0    = 3'd2,
    CMD_WRITE1    = 3'd3,
    CMD_PULLUP    = 3'd4,
    CMD_PULLDOWN  = 3'd5,
    CMD_RELEASE   = 3'd6,
    CMD_NONE      = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_GAP,
    ST_TAIL,
    ST_HOLD_UP,
    ST_HOLD_DN
  } state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RESET_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d};
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/swire_timer.sv
module swire_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/swire_seq.sv
module swire_seq
  import swire_pkg::*;
#(
  parameter int W        = 16,
  parameter int RST_LOW  = 500,
  parameter int RST_GAP  = 60,
  parameter int RST_TAIL = 421,
  parameter int RD_LOW   = 5,
  parameter int RD_GAP   = 6,
  parameter int RD_TAIL  = 50,
  parameter int W0_LOW   = 60,
  parameter int W0_TAIL  = 1,
  parameter int W1_LOW   = 10,
  parameter int W1_TAIL  = 51
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_code,
  input  logic         line_sync,
  input  logic         tmr_zero,
  output logic         tmr_load,
  output logic [W-1:0] tmr_val,
  output logic         busy,
  output logic         done,
  output logic         result,
  output logic         line_oe,
  output logic         line_drv
);
  localparam logic [W-1:0] RST_LOW_M1  = W'(RST_LOW - 1);
  localparam logic [W-1:0] RST_GAP_M1  = W'(RST_GAP - 1);
  localparam logic [W-1:0] RST_TAIL_M1 = W'(RST_TAIL - 1);
  localparam logic [W-1:0] RD_LOW_M1   = W'(RD_LOW - 1);
  localparam logic [W-1:0] RD_GAP_M1   = W'(RD_GAP - 1);
  localparam logic [W-1:0] RD_TAIL_M1  = W'(RD_TAIL - 1);
  localparam logic [W-1:0] W0_LOW_M1   = W'(W0_LOW - 1);
  localparam logic [W-1:0] W0_TAIL_M1  = W'(W0_TAIL - 1);
  localparam logic [W-1:0] W1_LOW_M1   = W'(W1_LOW - 1);
  localparam logic [W-1:0] W1_TAIL_M1  = W'(W1_TAIL - 1);

  state_e       state_q;
  logic [W-1:0] gap_q;
  logic [W-1:0] tail_q;
  logic         smp_q;
  logic         inv_q;
  cmd_e         cmd;

  assign cmd = cmd_e'(cmd_code);

  // Timer reload: first phase on accept, next phase when the current one ends.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          unique case (cmd)
            CMD_BUS_RESET: begin tmr_load = 1'b1; tmr_val = RST_LOW_M1; end
            CMD_READ:      begin tmr_load = 1'b1; tmr_val = RD_LOW_M1;  end
            CMD_WRITE0:    begin tmr_load = 1'b1; tmr_val = W0_LOW_M1;  end
            CMD_WRITE1:    begin tmr_load = 1'b1; tmr_val = W1_LOW_M1;  end
            default: ;
          endcase
        end
      end
      ST_LOW: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = smp_q ? gap_q : tail_q;
        end
      end
      ST_GAP: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = tail_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      gap_q    <= '0;
      tail_q   <= '0;
      smp_q    <= 1'b0;
      inv_q    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      result   <= 1'b0;
      line_oe  <= 1'b0;
      line_drv <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            unique case (cmd)
              CMD_BUS_RESET: begin
                state_q <= ST_LOW; busy <= 1'b1; line_oe <= 1'b1; result <= 1'b0;
                gap_q <= RST_GAP_M1; tail_q <= RST_TAIL_M1; smp_q <= 1'b1; inv_q <= 1'b1;
              end
              CMD_READ: begin
                state_q <= ST_LOW; busy <= 1'b1; line_oe <= 1'b1; result <= 1'b0;
                gap_q <= RD_GAP_M1; tail_q <= RD_TAIL_M1; smp_q <= 1'b1; inv_q <= 1'b0;
              end
              CMD_WRITE0: begin
                state_q <= ST_LOW; busy <= 1'b1; line_oe <= 1'b1; result <= 1'b0;
                gap_q <= '0; tail_q <= W0_TAIL_M1; smp_q <= 1'b0; inv_q <= 1'b0;
              end
              CMD_WRITE1: begin
                state_q <= ST_LOW; busy <= 1'b1; line_oe <= 1'b1; result <= 1'b0;
                gap_q <= '0; tail_q <= W1_TAIL_M1; smp_q <= 1'b0; inv_q <= 1'b0;
              end
              CMD_PULLUP: begin
                state_q <= ST_HOLD_UP; line_oe <= 1'b1; line_drv <= 1'b1;
              end
              CMD_PULLDOWN: begin
                state_q <= ST_HOLD_DN; line_oe <= 1'b1; line_drv <= 1'b0;
              end
              default: ;
            endcase
          end
        end
        ST_LOW: begin
          if (tmr_zero) begin
            line_oe <= 1'b0;
            state_q <= smp_q ? ST_GAP : ST_TAIL;
          end
        end
        ST_GAP: begin
          if (tmr_zero) begin
            result  <= line_sync ^ inv_q;
            state_q <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (tmr_zero) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_HOLD_UP, ST_HOLD_DN: begin
          if (cmd_valid && cmd == CMD_RELEASE) begin
            line_oe  <= 1'b0;
            line_drv <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swire_master.sv
module swire_master
  import swire_pkg::*;
#(
  parameter int CYC_PER_US  = 50,
  parameter int SYNC_STAGES = 2,
  parameter int RST_LOW_US  = 500,
  parameter int RST_GAP_US  = 60,
  parameter int RST_TAIL_US = 421,
  parameter int RD_LOW_US   = 5,
  parameter int RD_GAP_US   = 6,
  parameter int RD_TAIL_US  = 50,
  parameter int W0_LOW_US   = 60,
  parameter int W0_TAIL_US  = 1,
  parameter int W1_LOW_US   = 10,
  parameter int W1_TAIL_US  = 51
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  output logic       busy,
  output logic       done,
  output logic       result,
  input  logic       line_in,
  output logic       line_oe,
  output logic       line_drv
);
  localparam int LONGEST_US = imax(imax(imax(RST_LOW_US, RST_GAP_US), imax(RST_TAIL_US, RD_TAIL_US)),
                                   imax(imax(W0_LOW_US, W1_TAIL_US), imax(W1_LOW_US, RD_GAP_US)));
  localparam int LONGEST    = imax(LONGEST_US, imax(RD_LOW_US, W0_TAIL_US)) * CYC_PER_US;
  localparam int TW         = $clog2(LONGEST + 1);

  logic          line_sync;
  logic          tmr_zero;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;

  swire_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_in),
    .q   (line_sync)
  );

  swire_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  swire_seq #(
    .W        (TW),
    .RST_LOW  (RST_LOW_US  * CYC_PER_US),
    .RST_GAP  (RST_GAP_US  * CYC_PER_US),
    .RST_TAIL (RST_TAIL_US * CYC_PER_US),
    .RD_LOW   (RD_LOW_US   * CYC_PER_US),
    .RD_GAP   (RD_GAP_US   * CYC_PER_US),
    .RD_TAIL  (RD_TAIL_US  * CYC_PER_US),
    .W0_LOW   (W0_LOW_US   * CYC_PER_US),
    .W0_TAIL  (W0_TAIL_US  * CYC_PER_US),
    .W1_LOW   (W1_LOW_US   * CYC_PER_US),
    .W1_TAIL  (W1_TAIL_US  * CYC_PER_US)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .line_sync (line_sync),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .line_oe   (line_oe),
    .line_drv  (line_drv)
  );
endmodule

// File: rtl/swire_master_chk.sv
module swire_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       busy,
  input logic       done,
  input logic       result,
  input logic       line_oe,
  input logic       line_drv
);
  logic oe_q;
  logic released_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q       <= 1'b0;
      released_q <= 1'b0;
    end else begin
      oe_q <= line_oe;
      if (!busy)                released_q <= 1'b0;
      else if (oe_q && !line_oe) released_q <= 1'b1;
    end
  end

  p_drv_needs_oe_r7: assert property (@(posedge clk) disable iff (rst) line_drv |-> line_oe);
  p_drv_low_in_slot_r7: assert property (@(posedge clk) disable iff (rst) busy |-> !line_drv);
  p_slot_starts_low_r2: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> (line_oe && !line_drv));
  p_done_one_cycle_r11: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_not_busy_r11: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  p_busy_ends_done_r11: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  p_hold_stays_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && line_oe && !(cmd_valid && cmd_code == 3'd6)) |=> (line_oe && $stable(line_drv)));
  p_release_frees_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && line_oe && cmd_valid && cmd_code == 3'd6) |=> (!line_oe && !line_drv));
  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst) released_q |-> !line_oe);
endmodule

bind swire_master swire_master_chk u_chk (.*);

// File: tb/swire_master_tb.sv
module swire_master_tb_top;
  localparam int CPU = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd7;
  logic       dev_low = 1'b0;
  logic       busy, done, result, line_oe, line_drv;
  logic       line_in;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  // open-drain line: low if master drives low or the device pulls low
  assign line_in = !((line_oe && !line_drv) || dev_low);

  swire_master #(.CYC_PER_US(CPU)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .busy(busy), .done(done), .result(result),
    .line_in(line_in), .line_oe(line_oe), .line_drv(line_drv)
  );

  typedef struct packed {
    logic [2:0]  code;
    logic        dev;
    logic [15:0] low;
    logic [15:0] tot;
    logic        res;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{code: 3'd0, dev: 1'b1, low: 16'(500*CPU), tot: 16'(981*CPU), res: 1'b1},
    '{code: 3'd0, dev: 1'b0, low: 16'(500*CPU), tot: 16'(981*CPU), res: 1'b0},
    '{code: 3'd1, dev: 1'b0, low: 16'(5*CPU),   tot: 16'(61*CPU),  res: 1'b1},
    '{code: 3'd1, dev: 1'b1, low: 16'(5*CPU),   tot: 16'(61*CPU),  res: 1'b0},
    '{code: 3'd2, dev: 1'b0, low: 16'(60*CPU),  tot: 16'(61*CPU),  res: 1'b0},
    '{code: 3'd3, dev: 1'b0, low: 16'(10*CPU),  tot: 16'(61*CPU),  res: 1'b0}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd0: return "R2/R3";
      3'd1: return "R4";
      3'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic send(input logic [2:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 3'd7;
  endtask

  // Runs one slot; inj>0 pulses a bus-reset command at that busy cycle.
  task automatic run_slot(input logic [2:0] c, input int inj,
                          output int low_n, output int tot_n, output int res, output int drv_seen);
    low_n = 0; tot_n = 0; res = 0; drv_seen = 0;
    send(c);
    while (busy && tot_n < 20000) begin
      if (line_oe) low_n++;
      if (line_drv) drv_seen++;
      tot_n++;
      if (inj != 0 && tot_n == inj) begin
        cmd_valid = 1'b1; cmd_code = 3'd0;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 3'd7;
      end else begin
        @(negedge clk);
      end
    end
    check("R11 done with busy fall", int'(done), 1);
    res = int'(result);
    @(negedge clk);
    check("R11 done one cycle", int'(done), 0);
  endtask

  task automatic read_window(input int start_c, input int stop_c, input int exp);
    int n;
    send(3'd1);
    n = 0;
    while (line_oe && n < 100) begin @(negedge clk); n++; end
    repeat (start_c) @(negedge clk);
    dev_low = 1'b1;
    repeat (stop_c - start_c) @(negedge clk);
    dev_low = 1'b0;
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
    check("R4 sample point 6us after release", int'(result), exp);
  endtask

  initial begin
    int low_n, tot_n, res, drv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 line_oe", int'(line_oe), 0);
    check("R1 line_drv", int'(line_drv), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);

    // table of slot vectors
    for (int i = 0; i < 6; i++) begin
      dev_low = VECS[i].dev;
      run_slot(VECS[i].code, 0, low_n, tot_n, res, drv);
      dev_low = 1'b0;
      check({tag_of(VECS[i].code), " low time"}, low_n, int'(VECS[i].low));
      check({tag_of(VECS[i].code), " slot length"}, tot_n, int'(VECS[i].tot));
      check({tag_of(VECS[i].code), " result"}, res, int'(VECS[i].res));
      check("R7 drv low in slot", drv, 0);
    end

    // R4 sample timing: device low window before vs after the sample point
    read_window(3*CPU, 20*CPU, 0);
    read_window(8*CPU, 20*CPU, 1);

    // R10 command while busy is ignored
    run_slot(3'd3, 30, low_n, tot_n, res, drv);
    check("R10 busy ignore low time", low_n, 10*CPU);
    check("R10 busy ignore slot length", tot_n, 61*CPU);
    repeat (20) @(negedge clk);
    check("R10 no late slot busy", int'(busy), 0);
    check("R10 no late slot oe", int'(line_oe), 0);

    // R8 strong pull-up
    send(3'd4);
    check("R8 pull-up oe", int'(line_oe), 1);
    check("R8 pull-up drv", int'(line_drv), 1);
    check("R8 pull-up not busy", int'(busy), 0);
    send(3'd1);
    repeat (10) @(negedge clk);
    check("R10 read ignored in pull-up busy", int'(busy), 0);
    check("R10 read ignored in pull-up drv", int'(line_drv), 1);
    send(3'd5);
    check("R10 pull-down ignored in pull-up", int'(line_drv), 1);
    send(3'd6);
    check("R8 release oe", int'(line_oe), 0);
    check("R8 release drv", int'(line_drv), 0);

    // R9 forced pull-down
    send(3'd5);
    repeat (100) @(negedge clk);
    check("R9 pull-down oe", int'(line_oe), 1);
    check("R9 pull-down drv", int'(line_drv), 0);
    check("R9 line low", int'(line_in), 0);
    send(3'd2);
    repeat (5) @(negedge clk);
    check("R10 write ignored in pull-down", int'(busy), 0);
    check("R9 still held", int'(line_oe), 1);
    send(3'd6);
    check("R9 release oe", int'(line_oe), 0);

    // R12 codes 6 and 7 in idle
    send(3'd6);
    check("R12 code 6 idle busy", int'(busy), 0);
    check("R12 code 6 idle oe", int'(line_oe), 0);
    send(3'd7);
    repeat (5) @(negedge clk);
    check("R12 code 7 idle busy", int'(busy), 0);
    check("R12 code 7 idle oe", int'(line_oe), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule